// File: doc/BRIEF.md
# Sensor code to millidegree converter

This block turns a raw reading from an on-die temperature sensor into a signed temperature in thousandths of a degree Celsius. A 32-bit status word arrives on a valid/ready input stream. The block pulls the 12-bit code out of that word, multiplies it by a fixed gain, and divides the product by a fixed divisor that is not a power of two. The division uses a restoring divider that produces one quotient bit per clock. A fixed offset is then subtracted, and the signed result leaves on a valid/ready output stream.

An enable level travels alongside each request and is sampled in the cycle the request is accepted. If the sensor is not enabled at that point, the block skips the arithmetic. It returns a no-data indication in place of a temperature.

The unit handles one request at a time. The input is ready only while the unit is idle. A finished result stays on the output until the consumer takes it. Back-pressure on the output therefore stalls the input: while a result waits for `out_ready`, `in_ready` stays low and the upstream producer must hold its word.

Top module: `tsense_mdeg_conv`

## Requirements
- R1: The code is the unsigned field at bits 27 down to 16 of `in_word`. Bits 31:28 and 15:0 have no effect on the result.
- R2: With the sensor enabled, `out_mdeg` equals the integer part of code × 237500 / 4094, minus 81100. The quotient is truncated before the offset is subtracted. The result is a 21-bit two's complement value.
- R3: Code 0 yields −81100 and code 4095 yields 156458. Every valid temperature lies in that range.
- R4: If `in_enable` is low when a request is accepted, the result carries `out_nodata` = 1 and `out_mdeg` = 0. Otherwise `out_nodata` = 0.
- R5: `in_ready` is high only while the unit is idle. `busy` is high from the cycle after acceptance until the cycle after the output handshake, and `busy` is never high together with `in_ready`.
- R6: Once `out_valid` rises, `out_valid`, `out_mdeg` and `out_nodata` stay unchanged until a cycle with `out_ready` high.
- R7: After reset, `out_valid` and `busy` are low and `in_ready` is high.
- R8: `in_enable` is sampled only at acceptance. Changes to it during a conversion do not alter that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Status word offered |
| in_ready | output | 1 | Unit idle, word will be taken |
| in_word | input | 32 | Sensor status word carrying the code |
| in_enable | input | 1 | Sensor enabled, sampled at acceptance |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_mdeg | output | 21 | Signed temperature in millidegrees |
| out_nodata | output | 1 | Sensor was disabled, no temperature |
| busy | output | 1 | Conversion in flight or result pending |

## Verification
Two events can land in the same cycle: the output handshake and a new request on the input. The bench provokes this by raising `in_valid` with a fresh word in the same cycle that `out_ready` takes a pending result. It then checks three things:
- One cycle later the unit is idle and has not taken the word.
- The word is accepted on the following edge.
- The converted value of that word is correct.

A full sweep of all 4096 codes, with varying junk in the unused bits, compares each result against the integer formula computed in the bench.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_HOLD = 2'd2
  } conv_state_e;
endpackage

// File: rtl/tsc_code_scale.sv
// Extracts the code field and forms code * GAIN with a constant shift-add tree.
module tsc_code_scale #(
  parameter int WORD_W   = 32,
  parameter int CODE_LSB = 16,
  parameter int CODE_W   = 12,
  parameter int GAIN     = 237500,
  parameter int PROD_W   = 30
) (
  input  logic [WORD_W-1:0] word,
  output logic [PROD_W-1:0] product
);
  localparam int GAIN_W = $clog2(GAIN + 1);

  logic [CODE_W-1:0] code;
  logic [PROD_W-1:0] partial [GAIN_W];
  logic [PROD_W-1:0] acc     [GAIN_W+1];

  assign code   = word[CODE_LSB +: CODE_W];
  assign acc[0] = '0;

  for (genvar i = 0; i < GAIN_W; i++) begin : g_term
    localparam bit BIT_SET = ((GAIN >> i) & 1) != 0;
    if (BIT_SET) begin : g_on
      assign partial[i] = PROD_W'(code) << i;
    end else begin : g_off
      assign partial[i] = '0;
    end
    assign acc[i+1] = acc[i] + partial[i];
  end

  assign product = acc[GAIN_W];
endmodule

// File: rtl/tsc_restoring_div.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module tsc_restoring_div #(
  parameter int NW      = 30,
  parameter int DIVISOR = 4094
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  output logic [NW-1:0] quotient,
  output logic          done
);
  localparam int DW = $clog2(DIVISOR + 1);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, rem_nxt;
  logic [NW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   shifted;
  logic          ge;

  always_comb begin
    shifted = {rem_q, quo_q[NW-1]};
    ge      = shifted >= (DW+1)'(DIVISOR);
    rem_nxt = ge ? DW'(shifted - (DW+1)'(DIVISOR)) : shifted[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      quo_q <= dividend;
      cnt_q <= CW'(NW);
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q <= rem_nxt;
      quo_q <= {quo_q[NW-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CW'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  assign quotient = quo_q;
endmodule

// File: rtl/tsc_result_stage.sv
// Subtracts the offset and holds the result until it is taken.
module tsc_result_stage #(
  parameter int NW     = 30,
  parameter int RES_W  = 21,
  parameter int OFFSET = 81100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_val,
  input  logic                    load_nodata,
  input  logic [NW-1:0]           quotient,
  output logic signed [RES_W-1:0] mdeg,
  output logic                    nodata
);
  logic signed [RES_W-1:0] q_s, diff;

  always_comb begin
    q_s  = $signed(RES_W'(quotient));
    diff = q_s - $signed(RES_W'(OFFSET));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdeg   <= '0;
      nodata <= 1'b0;
    end else if (load_nodata) begin
      mdeg   <= '0;
      nodata <= 1'b1;
    end else if (load_val) begin
      mdeg   <= diff;
      nodata <= 1'b0;
    end
  end
endmodule

// File: rtl/tsense_mdeg_conv.sv
module tsense_mdeg_conv #(
  parameter int WORD_W   = 32,
  parameter int CODE_LSB = 16,
  parameter int CODE_W   = 12,
  parameter int GAIN     = 237500,
  parameter int DIVISOR  = 4094,
  parameter int OFFSET   = 81100,
  parameter int RES_W    = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_word,
  input  logic                    in_enable,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [RES_W-1:0] out_mdeg,
  output logic                    out_nodata,
  output logic                    busy
);
  import tsc_pkg::*;

  localparam int PROD_W = CODE_W + $clog2(GAIN + 1);

  conv_state_e       state_q;
  logic              accept, div_done, go_div, go_nodata, load_val;
  logic [PROD_W-1:0] product, quotient;

  assign accept    = in_valid && (state_q == ST_IDLE);
  assign go_div    = accept && in_enable;
  assign go_nodata = accept && !in_enable;
  assign load_val  = (state_q == ST_DIV) && div_done;

  tsc_code_scale #(
    .WORD_W(WORD_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W),
    .GAIN(GAIN), .PROD_W(PROD_W)
  ) u_scale (
    .word(in_word), .product(product)
  );

  tsc_restoring_div #(.NW(PROD_W), .DIVISOR(DIVISOR)) u_div (
    .clk(clk), .rst_n(rst_n), .start(go_div), .dividend(product),
    .quotient(quotient), .done(div_done)
  );

  tsc_result_stage #(.NW(PROD_W), .RES_W(RES_W), .OFFSET(OFFSET)) u_res (
    .clk(clk), .rst_n(rst_n), .load_val(load_val), .load_nodata(go_nodata),
    .quotient(quotient), .mdeg(out_mdeg), .nodata(out_nodata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept)    state_q <= in_enable ? ST_DIV : ST_HOLD;
        ST_DIV:  if (div_done)  state_q <= ST_HOLD;
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default:                state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/tsc_conv_checker.sv
module tsc_conv_checker #(
  parameter int CODE_W  = 12,
  parameter int GAIN    = 237500,
  parameter int DIVISOR = 4094,
  parameter int OFFSET  = 81100,
  parameter int RES_W   = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [RES_W-1:0] out_mdeg,
  input logic                    out_nodata,
  input logic                    busy
);
  localparam longint HI = ((longint'(2**CODE_W) - 1) * GAIN) / DIVISOR - OFFSET;
  localparam longint LO = -longint'(OFFSET);

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && in_ready));                                                  // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);                                      // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mdeg) && $stable(out_nodata))); // R6
  AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nodata) |-> (longint'(out_mdeg) >= LO && longint'(out_mdeg) <= HI)); // R3
  AST_NODATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nodata) |-> (out_mdeg == '0));                       // R4
  AST_IDLE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));                // R5
endmodule

bind tsense_mdeg_conv tsc_conv_checker #(
  .CODE_W(CODE_W), .GAIN(GAIN), .DIVISOR(DIVISOR), .OFFSET(OFFSET), .RES_W(RES_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_mdeg(out_mdeg),
  .out_nodata(out_nodata), .busy(busy)
);

// File: tb/tsense_mdeg_conv_bench.sv
module tsense_mdeg_conv_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [31:0]        in_word = '0;
  logic               in_enable = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic signed [20:0] out_mdeg;
  logic               out_nodata;
  logic               busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tsense_mdeg_conv u_tsense_mdeg_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_enable(in_enable), .out_valid(out_valid),
    .out_ready(out_ready), .out_mdeg(out_mdeg), .out_nodata(out_nodata),
    .busy(busy)
  );

  function automatic int model(input int code);
    return (code * 237500) / 4094 - 81100;
  endfunction

  function automatic logic [31:0] pack(input int code);
    logic [3:0]  hi = 4'(code) ^ 4'h5;
    logic [15:0] lo = 16'(code * 16'h9E37);
    return {hi, 12'(code), lo};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Issue one request; hold result for 'hold' cycles before taking it.
  task automatic convert(input logic [31:0] w, input logic en, input int hold,
                         input logic drop_en, output int mdeg, output logic nd);
    @(negedge clk);
    in_word = w; in_enable = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (drop_en) in_enable = ~en;
    while (!out_valid) @(negedge clk);
    mdeg = int'(out_mdeg);
    nd   = out_nodata;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R6 hold valid", int'(out_valid), 1);
      check("R6 hold value", int'(out_mdeg), mdeg);
      check("R6 hold nodata", int'(out_nodata), int'(nd));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int   v;
    logic nd;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 out_valid", int'(out_valid), 0);
    check("R7 busy", int'(busy), 0);
    check("R7 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 endpoints
    convert(pack(0), 1'b1, 0, 1'b0, v, nd);
    check("R3 code0", v, -81100);
    convert(pack(4095), 1'b1, 0, 1'b0, v, nd);
    check("R3 code4095", v, 156458);

    // R1 junk in unused bits must not matter
    convert(32'hF000_FFFF | (32'd1234 << 16), 1'b1, 0, 1'b0, v, nd);
    check("R1 junk ones", v, model(1234));
    convert(32'd1234 << 16, 1'b1, 0, 1'b0, v, nd);
    check("R1 junk zeros", v, model(1234));

    // R4 no-data
    convert(pack(2000), 1'b0, 2, 1'b0, v, nd);
    check("R4 nodata flag", int'(nd), 1);
    check("R4 nodata value", v, 0);
    check("R5 idle after take", int'(busy) * 2 + int'(in_ready), 1);

    // R8 enable changed mid conversion
    convert(pack(3000), 1'b1, 0, 1'b1, v, nd);
    check("R8 value", v, model(3000));
    check("R8 nodata", int'(nd), 0);
    convert(pack(3000), 1'b0, 0, 1'b1, v, nd);
    check("R8 nodata kept", int'(nd), 1);

    // R6 back-pressure with a valid result
    convert(pack(777), 1'b1, 5, 1'b0, v, nd);
    check("R6 value", v, model(777));

    // R5 busy after accept
    @(negedge clk);
    in_word = pack(100); in_enable = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 busy", int'(busy), 1);
    check("R5 in_ready low", int'(in_ready), 0);
    while (!out_valid) @(negedge clk);
    check("R2 code100", int'(out_mdeg), model(100));
    // handshake and new request in the same cycle
    out_ready = 1'b1;
    in_word = pack(4000); in_enable = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R5 not taken in handshake cycle", int'(busy), 0);
    check("R5 ready after handshake", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 taken next edge", int'(busy), 1);
    while (!out_valid) @(negedge clk);
    check("R2 code4000", int'(out_mdeg), model(4000));
    @(negedge clk);
    out_ready = 1'b0;

    // R2 full sweep
    for (int c = 0; c < 4096; c++) begin
      convert(pack(c), 1'b1, 0, 1'b0, v, nd);
      check("R2 sweep", v, model(c));
    end
    finish_run();
  end
endmodule